// File: doc/BRIEF.md
# Floating-Point Result Rounder

This block takes the final step of a floating-point arithmetic pipe. It receives a significand that is already normalized, or already placed in correct denormalized form. With the significand come its biased exponent, its sign and three extra bits below the significand (guard, round, sticky). The block rounds the value to double or single precision, using one of four rounding directions. The result is the rounded significand, with every position below the target precision cleared, and the exponent after any adjustment. Two flags come with it: one says the result differs from the exact value, and one says the exponent has overflowed.

In single precision the rounding point sits inside the 53-bit significand. The bits below that point then supply the guard and round bits. The rest of them, together with the three incoming extra bits, fold into sticky. A rounding increment can carry out of the top of the retained field. When it does, the block shifts the significand right by one and adds one to the exponent. The block does not normalize before rounding. The datapath is combinational. The `OUT_REG` parameter adds a register stage at the output, and it is on by default.

Top module: `fp_round_unit`

## Requirements
- R1: When `isSingle` is 1, the retained field is `sigIn[52:29]` and guard is `sigIn[28]`. Round is `sigIn[27]`, and sticky is the OR of `sigIn[26:0]`, `gIn`, `rIn` and `xIn`. When `isSingle` is 0, all 53 bits are retained and `gIn`, `rIn` and `xIn` are the guard, round and sticky bits.
- R2: With `modeIn` = 00 (nearest), a clear guard bit truncates. A set guard bit with round or sticky set adds one unit in the last retained place. A set guard bit with round and sticky both clear is a tie, and it adds one only when the retained LSB is 1 (ties go to even).
- R3: With `modeIn` = 01 (toward zero), the retained bits are always truncated.
- R4: With `modeIn` = 10 (toward +infinity), one unit is added only when `signIn` is 0 and any of guard, round or sticky is set.
- R5: With `modeIn` = 11 (toward −infinity), one unit is added only when `signIn` is 1 and any of guard, round or sticky is set.
- R6: `inexactOut` is 1 exactly when any of guard, round or sticky (as defined in R1) is 1.
- R7: When the increment carries out of the retained field, `sigOut` is bit 52 set with all other bits clear, and `expOut` is `expIn` + 1.
- R8: In single precision, `sigOut[28:0]` is always zero.
- R9: `ovfOut` is 1 exactly when a rounding carry occurs and `expIn` + 1 exceeds 2046 (double) or 254 (single).
- R10: When guard, round and sticky are all zero, `sigOut` equals `sigIn` and `expOut` equals `expIn`.
- R11: With `OUT_REG` = 1, the outputs reflect the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| modeIn | input | 2 | Rounding direction: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward −inf |
| isSingle | input | 1 | 1 = round to single precision, 0 = double |
| signIn | input | 1 | Sign of the value (1 = negative) |
| sigIn | input | 53 | Intermediate significand, bit 52 most significant |
| expIn | input | 12 | Biased exponent of the intermediate value |
| gIn | input | 1 | Guard bit below the significand |
| rIn | input | 1 | Round bit below the significand |
| xIn | input | 1 | Sticky bit below the significand |
| sigOut | output | 53 | Rounded significand, unused low bits cleared |
| expOut | output | 12 | Exponent after carry adjustment |
| inexactOut | output | 1 | Rounding discarded nonzero bits |
| ovfOut | output | 1 | Exponent overflow caused by the rounding carry |

## Verification
A wrong extraction of guard, round or sticky shows up in the inexact flag and the chosen increment. This happens on the very next registered output, because the block holds no state beyond the output stage. A bad increment decision or increment position shows as a significand that is off by one unit, or as stray low bits in single precision. A lost carry leaves the exponent one short and the overflow flag low at the format limit. Every such fault is therefore visible one cycle after the offending operand, which is why each directed operand is compared against an independent model at that cycle.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_TOZERO  = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } roundMode_e;

  // Bits the datapath exposes to the rounding decision
  typedef struct packed {
    logic guard;
    logic round;
    logic sticky;
    logic lsb;
  } grsView_t;

  // Strobes the decision logic hands back to the datapath
  typedef struct packed {
    logic incr;
    logic inexact;
  } roundStrobe_t;

endpackage

// File: rtl/fp_round_ctrl.sv
module fp_round_ctrl
  import fp_round_pkg::*;
(
  input  roundMode_e   mode,
  input  logic         sign,
  input  grsView_t     view,
  output roundStrobe_t strobe
);

  logic lostBits;

  always_comb begin
    lostBits       = view.guard | view.round | view.sticky;
    strobe.inexact = lostBits;
    unique case (mode)
      RM_NEAREST: strobe.incr = view.guard & (view.round | view.sticky | view.lsb);
      RM_TOZERO:  strobe.incr = 1'b0;
      RM_UP:      strobe.incr = lostBits & ~sign;
      RM_DOWN:    strobe.incr = lostBits & sign;
      default:    strobe.incr = 1'b0;
    endcase
  end

  always_comb begin
    // R3
    if (mode == RM_TOZERO) tozero_trunc_chk: assert (!strobe.incr);
    // R2
    if (mode == RM_NEAREST && !view.guard) nearest_low_chk: assert (!strobe.incr);
  end

endmodule

// File: rtl/fp_round_dp.sv
module fp_round_dp
  import fp_round_pkg::*;
#(
  parameter int SIG_W    = 53,
  parameter int SGL_W    = 24,
  parameter int EXP_W    = 12,
  parameter int DBL_EMAX = 2046,
  parameter int SGL_EMAX = 254
) (
  input  logic             isSingle,
  input  logic [SIG_W-1:0] sigIn,
  input  logic [EXP_W-1:0] expIn,
  input  logic             gIn,
  input  logic             rIn,
  input  logic             xIn,
  input  roundStrobe_t     strobe,
  output grsView_t         view,
  output logic [SIG_W-1:0] sigOut,
  output logic [EXP_W-1:0] expOut,
  output logic             ovf
);

  localparam int DROP = SIG_W - SGL_W;
  localparam logic [SIG_W-1:0] SGL_MASK = {{SGL_W{1'b1}}, {DROP{1'b0}}};
  localparam logic [SIG_W:0]   DBL_ULP  = (SIG_W+1)'(1);
  localparam logic [SIG_W:0]   SGL_ULP  = (SIG_W+1)'(1) << DROP;
  localparam logic [EXP_W:0]   DBL_LIM  = (EXP_W+1)'(DBL_EMAX);
  localparam logic [EXP_W:0]   SGL_LIM  = (EXP_W+1)'(SGL_EMAX);
  localparam logic [SIG_W-1:0] TOP_ONE  = {1'b1, {(SIG_W-1){1'b0}}};

  logic [SIG_W-1:0] keptSig;
  logic [SIG_W:0]   addend;
  logic [SIG_W:0]   sumSig;
  logic [SIG_W-1:0] shiftSig;
  logic             carryOut;
  logic [EXP_W:0]   expWide;
  logic [EXP_W:0]   expLim;

  // guard/round/sticky extraction, position set by target precision
  always_comb begin
    if (isSingle) begin
      view.guard  = sigIn[DROP-1];
      view.round  = sigIn[DROP-2];
      view.sticky = (|sigIn[DROP-3:0]) | gIn | rIn | xIn;
      view.lsb    = sigIn[DROP];
    end else begin
      view.guard  = gIn;
      view.round  = rIn;
      view.sticky = xIn;
      view.lsb    = sigIn[0];
    end
  end

  // increment at the last retained place, then renormalize on carry
  always_comb begin
    keptSig  = isSingle ? (sigIn & SGL_MASK) : sigIn;
    addend   = strobe.incr ? (isSingle ? SGL_ULP : DBL_ULP) : '0;
    sumSig   = {1'b0, keptSig} + addend;
    carryOut = sumSig[SIG_W];
    shiftSig = carryOut ? sumSig[SIG_W:1] : sumSig[SIG_W-1:0];
    sigOut   = isSingle ? (shiftSig & SGL_MASK) : shiftSig;
  end

  always_comb begin
    expWide = {1'b0, expIn} + (EXP_W+1)'(carryOut);
    expOut  = expWide[EXP_W-1:0];
    expLim  = isSingle ? SGL_LIM : DBL_LIM;
    ovf     = carryOut && (expWide > expLim);
  end

  always_comb begin
    // R7
    if (carryOut) carry_renorm_chk: assert (sigOut == TOP_ONE);
    // R8
    if (isSingle) single_mask_chk: assert (sigOut[DROP-1:0] == '0);
    // R10
    if (!strobe.inexact) exact_pass_chk: assert (sigOut == sigIn && expOut == expIn);
    // R9
    if (ovf) ovf_needs_inexact_chk: assert (strobe.inexact && strobe.incr);
  end

endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
  import fp_round_pkg::*;
#(
  parameter int SIG_W    = 53,
  parameter int SGL_W    = 24,
  parameter int EXP_W    = 12,
  parameter int DBL_EMAX = 2046,
  parameter int SGL_EMAX = 254,
  parameter bit OUT_REG  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       modeIn,
  input  logic             isSingle,
  input  logic             signIn,
  input  logic [SIG_W-1:0] sigIn,
  input  logic [EXP_W-1:0] expIn,
  input  logic             gIn,
  input  logic             rIn,
  input  logic             xIn,
  output logic [SIG_W-1:0] sigOut,
  output logic [EXP_W-1:0] expOut,
  output logic             inexactOut,
  output logic             ovfOut
);

  grsView_t         view;
  roundStrobe_t     strobe;
  logic [SIG_W-1:0] sigNext;
  logic [EXP_W-1:0] expNext;
  logic             ovfNext;

  fp_round_ctrl u_ctrl (
    .mode   (roundMode_e'(modeIn)),
    .sign   (signIn),
    .view   (view),
    .strobe (strobe)
  );

  fp_round_dp #(
    .SIG_W    (SIG_W),
    .SGL_W    (SGL_W),
    .EXP_W    (EXP_W),
    .DBL_EMAX (DBL_EMAX),
    .SGL_EMAX (SGL_EMAX)
  ) u_dp (
    .isSingle (isSingle),
    .sigIn    (sigIn),
    .expIn    (expIn),
    .gIn      (gIn),
    .rIn      (rIn),
    .xIn      (xIn),
    .strobe   (strobe),
    .view     (view),
    .sigOut   (sigNext),
    .expOut   (expNext),
    .ovf      (ovfNext)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sigOut     <= '0;
          expOut     <= '0;
          inexactOut <= 1'b0;
          ovfOut     <= 1'b0;
        end else begin
          sigOut     <= sigNext;
          expOut     <= expNext;
          inexactOut <= strobe.inexact;
          ovfOut     <= ovfNext;
        end
      end

      // R9
      ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovfOut |-> (inexactOut && sigOut[SIG_W-1] && sigOut[SIG_W-2:0] == '0));
    end else begin : g_comb
      always_comb begin
        sigOut     = sigNext;
        expOut     = expNext;
        inexactOut = strobe.inexact;
        ovfOut     = ovfNext;
      end
    end
  endgenerate

endmodule

// File: tb/fp_round_unit_bench.sv
`timescale 1ns/1ps
module fp_round_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  modeIn = '0;
  logic        isSingle = 1'b0;
  logic        signIn = 1'b0;
  logic [52:0] sigIn = '0;
  logic [11:0] expIn = '0;
  logic        gIn = 1'b0, rIn = 1'b0, xIn = 1'b0;
  logic [52:0] sigOut;
  logic [11:0] expOut;
  logic        inexactOut, ovfOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fp_round_unit u_fp_round_unit (
    .clk(clk), .rst_n(rst_n), .modeIn(modeIn), .isSingle(isSingle),
    .signIn(signIn), .sigIn(sigIn), .expIn(expIn), .gIn(gIn), .rIn(rIn),
    .xIn(xIn), .sigOut(sigOut), .expOut(expOut), .inexactOut(inexactOut),
    .ovfOut(ovfOut)
  );

  localparam logic [52:0] ALL1 = {53{1'b1}};
  localparam logic [52:0] TOP1 = {1'b1, 52'd0};

  // independent model written from the requirements
  task automatic refModel(input logic [1:0] m, input logic sgl, input logic s,
                          input logic [52:0] sg, input logic [11:0] e,
                          input logic g, input logic r, input logic x,
                          output logic [52:0] eSig, output logic [11:0] eExp,
                          output logic eInx, output logic eOvf);
    logic [53:0] kept;
    logic gg, rr, ss, lsb, lost, up, carry;
    int lim;
    if (sgl) begin
      kept = {30'd0, sg[52:29]};
      gg = sg[28]; rr = sg[27]; ss = (sg[26:0] != 0) || g || r || x;
      lim = 254;
    end else begin
      kept = {1'b0, sg};
      gg = g; rr = r; ss = x;
      lim = 2046;
    end
    lsb  = kept[0];
    lost = gg || rr || ss;
    case (m)
      2'b00: up = gg && (rr || ss || lsb);
      2'b01: up = 1'b0;
      2'b10: up = lost && !s;
      default: up = lost && s;
    endcase
    kept  = kept + {53'd0, up};
    carry = sgl ? kept[24] : kept[53];
    if (carry) begin
      eSig = TOP1;
      eExp = e + 12'd1;
    end else begin
      eSig = sgl ? {kept[23:0], 29'd0} : kept[52:0];
      eExp = e;
    end
    eInx = lost;
    eOvf = carry && (int'(e) + 1 > lim);
  endtask

  task automatic apply(input string tag, input logic [1:0] m, input logic sgl,
                       input logic s, input logic [52:0] sg, input logic [11:0] e,
                       input logic g, input logic r, input logic x);
    logic [52:0] eSig; logic [11:0] eExp; logic eInx, eOvf;
    @(negedge clk);
    modeIn = m; isSingle = sgl; signIn = s; sigIn = sg; expIn = e;
    gIn = g; rIn = r; xIn = x;
    @(negedge clk);
    refModel(m, sgl, s, sg, e, g, r, x, eSig, eExp, eInx, eOvf);
    checks++;
    if (sigOut !== eSig || expOut !== eExp || inexactOut !== eInx || ovfOut !== eOvf) begin
      fails++;
      $display("FAIL %s: got sig=%h exp=%0d inx=%b ovf=%b exp'd sig=%h exp=%0d inx=%b ovf=%b",
               tag, sigOut, expOut, inexactOut, ovfOut, eSig, eExp, eInx, eOvf);
    end
  endtask

  task automatic expectBits(input string tag, input logic [52:0] gotS, input logic [52:0] wantS);
    checks++;
    if (gotS !== wantS) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, gotS, wantS);
    end
  endtask

  task automatic testReset();
    // R11: outputs zero during reset
    @(negedge clk);
    checks++;
    if (sigOut !== '0 || expOut !== '0 || inexactOut !== 1'b0 || ovfOut !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset: got sig=%h exp=%0d inx=%b ovf=%b expected all zero",
               sigOut, expOut, inexactOut, ovfOut);
    end
  endtask

  task automatic testNearest();
    // R2: double ties, above and below half
    apply("R2 tie even dbl", 2'b00, 0, 0, 53'h10_0000_0000_0002, 12'd1000, 1, 0, 0);
    apply("R2 tie odd dbl",  2'b00, 0, 0, 53'h10_0000_0000_0003, 12'd1000, 1, 0, 0);
    apply("R2 above half",   2'b00, 0, 1, 53'h10_0000_0000_0002, 12'd1000, 1, 0, 1);
    apply("R2 below half",   2'b00, 0, 0, 53'h10_0000_0000_0003, 12'd1000, 0, 1, 1);
    // single tie: bit 28 set, retained LSB (bit 29) even then odd
    apply("R2 tie even sgl", 2'b00, 1, 0, TOP1 | (53'd1 << 28), 12'd100, 0, 0, 0);
    apply("R2 tie odd sgl",  2'b00, 1, 0, TOP1 | (53'd3 << 28), 12'd100, 0, 0, 0);
  endtask

  task automatic testDirected();
    apply("R3 toward zero pos", 2'b01, 0, 0, 53'h1F_0000_0000_0001, 12'd50, 1, 1, 1);
    apply("R3 toward zero neg", 2'b01, 1, 1, TOP1 | (53'h7 << 26), 12'd50, 1, 1, 1);
    apply("R4 up positive",     2'b10, 0, 0, 53'h10_0000_0000_0004, 12'd60, 0, 0, 1);
    apply("R4 up negative",     2'b10, 0, 1, 53'h10_0000_0000_0004, 12'd60, 0, 0, 1);
    apply("R5 down negative",   2'b11, 0, 1, 53'h10_0000_0000_0004, 12'd60, 0, 1, 0);
    apply("R5 down positive",   2'b11, 0, 0, 53'h10_0000_0000_0004, 12'd60, 0, 1, 0);
  endtask

  task automatic testFold();
    // R1: lowest significand bit alone must set sticky in single
    apply("R1 fold sig bit0", 2'b10, 1, 0, TOP1 | 53'd1, 12'd77, 0, 0, 0);
    apply("R1 fold gIn",      2'b10, 1, 0, TOP1, 12'd77, 1, 0, 0);
    // R1: in double, low significand bits are retained, not sticky
    apply("R1 dbl retains",   2'b10, 0, 0, TOP1 | 53'd1, 12'd77, 0, 0, 0);
    // R6: exact value flags no inexact
    apply("R6 exact flag",    2'b00, 1, 0, TOP1 | (53'd5 << 29), 12'd77, 0, 0, 0);
  endtask

  task automatic testCarry();
    // R7/R9: all-ones significands in every mode and both precisions
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 2; p++) begin
        apply("R7 all-ones carry", 2'(m), 1'(p), 1'(m == 3),
              p ? {24'hFFFFFF, 29'd0} : ALL1, 12'd500, 1, 1, 1);
      end
    end
    apply("R9 dbl overflow",   2'b10, 0, 0, ALL1, 12'd2046, 0, 0, 1);
    apply("R9 dbl below lim",  2'b10, 0, 0, ALL1, 12'd2045, 0, 0, 1);
    apply("R9 sgl overflow",   2'b00, 1, 0, ALL1, 12'd254, 0, 0, 0);
    apply("R9 sgl below lim",  2'b00, 1, 0, ALL1, 12'd253, 0, 0, 0);
  endtask

  task automatic testMaskExact();
    // R8: low 29 bits cleared in single
    apply("R8 single mask", 2'b01, 1, 0, 53'h1A_5A5A_5A5A_5A5A, 12'd9, 0, 0, 0);
    expectBits("R8 low bits", {24'd0, sigOut[28:0]}, '0);
    // R10: exact double passes through unchanged
    apply("R10 exact dbl", 2'b10, 0, 0, 53'h15_5555_5555_5555, 12'd1234, 0, 0, 0);
    expectBits("R10 passthrough", sigOut, 53'h15_5555_5555_5555);
  endtask

  task automatic testLatency();
    logic [52:0] prev;
    // R11: new operand must not appear before the next rising edge
    apply("R11 setup", 2'b01, 0, 0, 53'h12_3456_789A_BCDE, 12'd3, 0, 0, 0);
    prev = sigOut;
    modeIn = 2'b01; isSingle = 0; sigIn = 53'h1F_EDCB_A987_6543; gIn = 0; rIn = 0; xIn = 0;
    #1;
    expectBits("R11 hold before edge", sigOut, prev);
    @(negedge clk);
    expectBits("R11 after edge", sigOut, 53'h1F_EDCB_A987_6543);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, got no completion expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    testNearest();
    testDirected();
    testFold();
    testCarry();
    testMaskExact();
    testLatency();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule